// File: doc/BRIEF.md
# Interrupt Cause Register and INTx Router

This block gathers interrupt events into a 32-bit cause register that software clears by writing zeros. Bit 0 of the cause register is not stored on its own: it always reports whether any of bits 31:1 is pending. A CPU mask register selects which cause bits drive the CPU interrupt output. A PCI mask and an SERR mask are stored and read back only; their effect lies outside this block.

The second half of the block routes level-sensitive PCI interrupts. Each device supplies a level, its slot number and the pin it drives (0 = INTA through 3 = INTD). Slots 18 to 21 are rotated onto the four INTx lines. Every other slot keeps its pin unchanged. A routing register holds one entry per INTx line naming an interrupt-controller input. Each controller input carries the OR of every INTx line routed to it.

Top module: `irq_router_top`

## Requirements
- R1: After a synchronous reset, the cause register, the three mask registers and the routing register are zero, and `cpu_irq` and `intc_out` are low.
- R2: A write to address 0 (cause) computes new bits 31:1 = old AND `wr_data`. Writing 0 clears a bit, writing 1 keeps it, and `wr_data[0]` has no effect.
- R3: After every update, cause bit 0 equals the OR of cause bits 31:1.
- R4: A high bit of `cause_ev[31:1]` sets the matching cause bit at the next edge. If the same bit is set and cleared by a write in the same cycle, the set wins.
- R5: A write to address 1 stores `wr_data & 32'h3C3F_FFFE` as the CPU mask.
- R6: A write to address 2 stores `wr_data & 32'h03FF_FFFE` as the PCI mask. A write to address 3 stores `wr_data & 32'h0000_003F` as the SERR mask.
- R7: `cpu_irq` is high one cycle after the registers hold a cause value whose AND with the CPU mask has any bit set among bits 31:1. Otherwise it is low.
- R8: A device in slots 18 to 21 drives INTx line ((slot - 18) + pin) & 3. A device in any other slot drives line `pin`.
- R9: Address 4 holds the routing register. Byte k holds the output index for INTx line k; only its low log2(NUM_OUTS) bits are stored, and the rest read as zero. `intc_out[o]` is registered, one cycle after the device inputs, and equals the OR of all INTx lines whose entry is o.
- R10: `rd_data` presents the register at `rd_addr` one cycle later. Addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Registered read data |
| cause_ev | input | 31 | One-cycle event pulses for cause bits 31:1 |
| cpu_irq | output | 1 | Masked CPU interrupt |
| dev_level | input | NUM_DEVS | Device interrupt levels |
| dev_slot | input | NUM_DEVS*5 | Device slot numbers, packed |
| dev_pin | input | NUM_DEVS*2 | Device pin numbers, packed |
| intc_out | output | NUM_OUTS | Interrupt-controller input levels |

## Verification
The hardest case to reach is a set and a clear of the same cause bit in one cycle. The bench gets there by raising an event pulse in the same cycle as a cause write of all zeros, then reads the result back. The second hard case is the merging of several INTx lines onto one output, with devices both inside and outside the rotated slot range. The bench routes two lines to one output and sweeps all sixteen combinations of device levels against its own swizzle model.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NUM_INTX = 4;
  localparam int SLOT_W   = 5;
  localparam logic [31:0] CPU_MASK_BITS  = 32'h3C3F_FFFE;
  localparam logic [31:0] PCI_MASK_BITS  = 32'h03FF_FFFE;
  localparam logic [31:0] SERR_MASK_BITS = 32'h0000_003F;

  typedef enum logic [2:0] {
    A_CAUSE    = 3'd0,
    A_CPU_MASK = 3'd1,
    A_PCI_MASK = 3'd2,
    A_SERR     = 3'd3,
    A_ROUTE    = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_cause_regs.sv
module irq_cause_regs
  import irq_router_pkg::*;
#(
  parameter int ROUTE_W = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  input  logic [31:1] cause_ev,
  output logic [31:0] rd_data,
  output logic [31:0] cause_q,
  output logic [31:0] cpu_mask_q,
  output logic [NUM_INTX-1:0][ROUTE_W-1:0] route_q,
  output logic        cpu_irq
);
  logic [31:0] pci_mask_q;
  logic [31:0] serr_mask_q;
  logic [31:1] pend;
  logic [31:0] cause_nxt;
  logic [31:0] rd_mux;
  logic [31:0] route_rd;

  always_comb begin
    pend = cause_q[31:1];
    if (wr_en && wr_addr == A_CAUSE) pend = pend & wr_data[31:1];
    pend = pend | cause_ev;
    cause_nxt = {pend, |pend};
  end

  always_comb begin
    route_rd = '0;
    for (int i = 0; i < NUM_INTX; i++) route_rd[8*i +: 8] = 8'(route_q[i]);
    case (rd_addr)
      A_CAUSE:    rd_mux = cause_q;
      A_CPU_MASK: rd_mux = cpu_mask_q;
      A_PCI_MASK: rd_mux = pci_mask_q;
      A_SERR:     rd_mux = serr_mask_q;
      A_ROUTE:    rd_mux = route_rd;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q     <= '0;
      cpu_mask_q  <= '0;
      pci_mask_q  <= '0;
      serr_mask_q <= '0;
      route_q     <= '0;
      cpu_irq     <= 1'b0;
      rd_data     <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_CPU_MASK: cpu_mask_q  <= wr_data & CPU_MASK_BITS;
          A_PCI_MASK: pci_mask_q  <= wr_data & PCI_MASK_BITS;
          A_SERR:     serr_mask_q <= wr_data & SERR_MASK_BITS;
          A_ROUTE: begin
            for (int i = 0; i < NUM_INTX; i++) route_q[i] <= wr_data[8*i +: ROUTE_W];
          end
          default: ;
        endcase
      end
      cause_q <= cause_nxt;
      cpu_irq <= |(cause_q[31:1] & cpu_mask_q[31:1]);
      rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_swizzle.sv
module irq_swizzle
  import irq_router_pkg::*;
#(
  parameter int NUM_DEVS  = 4,
  parameter int SLOT_BASE = 18
) (
  input  logic [NUM_DEVS-1:0]        dev_level,
  input  logic [NUM_DEVS*SLOT_W-1:0] dev_slot,
  input  logic [NUM_DEVS*2-1:0]      dev_pin,
  output logic [NUM_INTX-1:0]        intx_level
);
  localparam logic [SLOT_W-1:0] BASE_V = SLOT_W'(SLOT_BASE);
  localparam logic [SLOT_W-1:0] TOP_V  = SLOT_W'(SLOT_BASE + NUM_INTX - 1);

  logic [NUM_DEVS-1:0][NUM_INTX-1:0] dev_hot;

  for (genvar d = 0; d < NUM_DEVS; d++) begin : g_dev
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] off;
    logic [1:0]        pin;
    logic [1:0]        line;
    always_comb begin
      slot = dev_slot[d*SLOT_W +: SLOT_W];
      pin  = dev_pin[d*2 +: 2];
      off  = slot - BASE_V;
      if (slot >= BASE_V && slot <= TOP_V) line = off[1:0] + pin;
      else line = pin;
      dev_hot[d] = '0;
      dev_hot[d][line] = dev_level[d];
    end
  end

  always_comb begin
    intx_level = '0;
    for (int d = 0; d < NUM_DEVS; d++) intx_level = intx_level | dev_hot[d];
  end
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_router_pkg::*;
#(
  parameter int NUM_OUTS = 16,
  parameter int ROUTE_W  = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_INTX-1:0]              intx_level,
  input  logic [NUM_INTX-1:0][ROUTE_W-1:0] route_q,
  output logic [NUM_OUTS-1:0]              intc_out
);
  logic [NUM_OUTS-1:0] out_nxt;

  for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out
    logic [NUM_INTX-1:0] hit;
    for (genvar i = 0; i < NUM_INTX; i++) begin : g_line
      assign hit[i] = intx_level[i] && (route_q[i] == ROUTE_W'(o));
    end
    assign out_nxt[o] = |hit;
  end

  always_ff @(posedge clk) begin
    if (rst) intc_out <= '0;
    else     intc_out <= out_nxt;
  end
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
#(
  parameter int NUM_DEVS  = 4,
  parameter int NUM_OUTS  = 16,
  parameter int SLOT_BASE = 18
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_addr,
  input  logic [31:0]                wr_data,
  input  logic [2:0]                 rd_addr,
  output logic [31:0]                rd_data,
  input  logic [31:1]                cause_ev,
  output logic                       cpu_irq,
  input  logic [NUM_DEVS-1:0]        dev_level,
  input  logic [NUM_DEVS*SLOT_W-1:0] dev_slot,
  input  logic [NUM_DEVS*2-1:0]      dev_pin,
  output logic [NUM_OUTS-1:0]        intc_out
);
  localparam int ROUTE_W = (NUM_OUTS > 1) ? $clog2(NUM_OUTS) : 1;

  logic [31:0]                      cause_q;
  logic [31:0]                      cpu_mask_q;
  logic [NUM_INTX-1:0][ROUTE_W-1:0] route_q;
  logic [NUM_INTX-1:0]              intx_level;

  irq_cause_regs #(.ROUTE_W(ROUTE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cause_ev(cause_ev), .rd_data(rd_data),
    .cause_q(cause_q), .cpu_mask_q(cpu_mask_q), .route_q(route_q), .cpu_irq(cpu_irq)
  );

  irq_swizzle #(.NUM_DEVS(NUM_DEVS), .SLOT_BASE(SLOT_BASE)) u_swz (
    .dev_level(dev_level), .dev_slot(dev_slot), .dev_pin(dev_pin),
    .intx_level(intx_level)
  );

  irq_route #(.NUM_OUTS(NUM_OUTS), .ROUTE_W(ROUTE_W)) u_route (
    .clk(clk), .rst(rst), .intx_level(intx_level), .route_q(route_q),
    .intc_out(intc_out)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_OUTS = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [2:0]          wr_addr,
  input logic [31:0]         wr_data,
  input logic [31:1]         cause_ev,
  input logic [31:0]         cause_q,
  input logic [31:0]         cpu_mask_q,
  input logic                cpu_irq,
  input logic [NUM_OUTS-1:0] intc_out
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (cause_q == '0 && cpu_mask_q == '0 && !cpu_irq && intc_out == '0));

  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd0 && cause_ev == '0) |=>
      (cause_q[31:1] == ($past(cause_q[31:1]) & $past(wr_data[31:1]))));

  p_summary_r3: assert property (@(posedge clk) disable iff (rst)
    cause_q[0] == (|cause_q[31:1]));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (|cause_ev) |=> ((cause_q[31:1] & $past(cause_ev)) == $past(cause_ev)));

  p_cpu_mask_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd1) |=> (cpu_mask_q == ($past(wr_data) & 32'h3C3F_FFFE)));

  p_cpu_irq_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == $past(|(cause_q[31:1] & cpu_mask_q[31:1])));
endmodule

bind irq_router_top irq_router_chk #(.NUM_OUTS(NUM_OUTS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cause_ev(cause_ev), .cause_q(cause_q), .cpu_mask_q(cpu_mask_q),
  .cpu_irq(cpu_irq), .intc_out(intc_out)
);

// File: tb/irq_router_top_bench.sv
module irq_router_top_bench;
  localparam int ND = 4;
  localparam int NO = 16;

  logic          clk = 0;
  logic          rst = 1;
  logic          wr_en = 0;
  logic [2:0]    wr_addr = 0;
  logic [31:0]   wr_data = 0;
  logic [2:0]    rd_addr = 0;
  logic [31:0]   rd_data;
  logic [31:1]   cause_ev = 0;
  logic          cpu_irq;
  logic [ND-1:0] dev_level = 0;
  logic [ND*5-1:0] dev_slot = 0;
  logic [ND*2-1:0] dev_pin = 0;
  logic [NO-1:0] intc_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_router_top #(.NUM_DEVS(ND), .NUM_OUTS(NO), .SLOT_BASE(18)) u_irq_router_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cause_ev(cause_ev), .cpu_irq(cpu_irq),
    .dev_level(dev_level), .dev_slot(dev_slot), .dev_pin(dev_pin), .intc_out(intc_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    chk(rd_data, exp, req);
  endtask

  task automatic pulse(input logic [31:1] ev);
    @(negedge clk);
    cause_ev = ev;
    @(negedge clk);
    cause_ev = '0;
  endtask

  task automatic t_reset();
    chk({31'd0, cpu_irq}, 32'd0, "R1 cpu_irq");
    chk(32'(intc_out), 32'd0, "R1 intc_out");
    for (int a = 0; a < 5; a++) rd_chk(3'(a), 32'd0, "R1 register");
    rd_chk(3'd6, 32'd0, "R10 unused address");
  endtask

  task automatic t_masks();
    wr(3'd1, 32'hFFFF_FFFF);
    rd_chk(3'd1, 32'h3C3F_FFFE, "R5 cpu mask");
    wr(3'd2, 32'hFFFF_FFFF);
    rd_chk(3'd2, 32'h03FF_FFFE, "R6 pci mask");
    wr(3'd3, 32'hFFFF_FFFF);
    rd_chk(3'd3, 32'h0000_003F, "R6 serr mask");
  endtask

  task automatic t_cause();
    pulse(31'h0000_0009);
    rd_chk(3'd0, 32'h0000_0013, "R4 event set, R3 summary");
    wr(3'd0, 32'hFFFF_FFEF);
    rd_chk(3'd0, 32'h0000_0003, "R2 clear bit4");
    wr(3'd0, 32'hFFFF_FFFC);
    rd_chk(3'd0, 32'h0000_0000, "R2 R3 clear last bit");
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk(3'd0, 32'h0000_0000, "R2 write ones");
  endtask

  task automatic t_set_wins();
    @(negedge clk);
    wr_en = 1; wr_addr = 3'd0; wr_data = 32'h0; cause_ev = 31'h0000_0010;
    @(negedge clk);
    wr_en = 0; cause_ev = '0;
    rd_chk(3'd0, 32'h0000_0021, "R4 set wins over clear");
  endtask

  task automatic t_cpu_irq();
    @(negedge clk);
    chk({31'd0, cpu_irq}, 32'd1, "R7 masked-in cause");
    wr(3'd1, 32'h0);
    @(negedge clk);
    chk({31'd0, cpu_irq}, 32'd0, "R7 mask cleared");
    wr(3'd0, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    pulse(31'h2000_0000);
    @(negedge clk);
    chk({31'd0, cpu_irq}, 32'd0, "R7 bit30 outside mask");
    pulse(31'h1000_0000);
    @(negedge clk);
    chk({31'd0, cpu_irq}, 32'd1, "R7 bit29 inside mask");
  endtask

  function automatic logic [1:0] exp_line(input int slot, input int pin);
    if (slot >= 18 && slot <= 21) return 2'((slot - 18) + pin);
    return 2'(pin);
  endfunction

  task automatic t_route();
    int slots[ND] = '{18, 20, 5, 21};
    int pins[ND]  = '{0, 3, 2, 2};
    int rte[4]    = '{3, 3, 7, 15};
    wr(3'd4, {8'hFF, 8'd7, 8'd3, 8'd3});
    rd_chk(3'd4, 32'h0F07_0303, "R9 route readback");
    for (int d = 0; d < ND; d++) begin
      dev_slot[d*5 +: 5] = 5'(slots[d]);
      dev_pin[d*2 +: 2]  = 2'(pins[d]);
    end
    for (int p = 0; p < 16; p++) begin
      logic [3:0] lines;
      logic [NO-1:0] exp;
      lines = '0;
      exp = '0;
      for (int d = 0; d < ND; d++)
        if (p[d]) lines[exp_line(slots[d], pins[d])] = 1'b1;
      for (int l = 0; l < 4; l++) if (lines[l]) exp[rte[l]] = 1'b1;
      @(negedge clk);
      dev_level = 4'(p);
      @(negedge clk);
      chk(32'(intc_out), 32'(exp), "R8 R9 swizzle and merge");
    end
    dev_level = '0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_masks();
    t_cause();
    t_set_wins();
    t_cpu_irq();
    t_route();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule